// File: doc/BRIEF.md
# Sixteen-bit eight-instruction processor core

A single-cycle processor core that executes a compact eight-operation instruction set over eight 16-bit general registers. Each clock cycle it presents the program counter on the instruction-memory address port and receives the instruction word back in the same cycle. It decodes that word in one of three layouts, executes it, and on the closing clock edge updates the register file and the program counter, or writes one word into data memory. Both memories are external and combinational-read, and they are addressed in whole 16-bit words.

Arithmetic is limited to a 16-bit adder and a NAND gate array. Large constants are built with an upper-immediate load followed by an immediate add. Register 0 is hardwired to zero. The core stops itself on a register-jump that has all of its fields cleared and holds its halt output until the next reset.

Top module: `core16_top`

## Requirements
- R1: While `rst` is high at a clock edge, the PC (`imem_addr`) becomes 0 and `halt` becomes 0. The first instruction after reset is fetched from address 0.
- R2: Register 0 always reads as 0, even after an instruction has named it as a destination. A store whose source field (bits 12:10) is 0 drives `dmem_wdata` = 0.
- R3: Opcode 000 writes regB+regC into regA, and opcode 010 writes ~(regB & regC) into regA. In this layout regA is bits 12:10, regB is bits 9:7 and regC is bits 2:0.
- R4: Opcode 001 writes regB plus the sign-extended 7-bit immediate in bits 6:0 (range -64..63) into regA.
- R5: Opcode 011 writes the 10-bit unsigned field in bits 9:0 into bits 15:6 of regA and clears bits 5:0.
- R6: Opcode 100 raises `dmem_we` for that cycle only, with `dmem_addr` = regB+sext(imm) and `dmem_wdata` = regA. Opcode 101 loads regA from `dmem_rdata` at the same address. Addresses wrap modulo 2^16, and `dmem_we` is low for every other opcode.
- R7: Opcode 110 sets the next PC to PC+1+sext(imm) when regA equals regB, and to PC+1 when they differ. The offset may be negative.
- R8: Opcode 111 writes PC+1 into regA and jumps to the value regB held before the write, including when regA and regB name the same register.
- R9: Opcode 111 with regA = 0, regB = 0 and imm = 0 sets `halt` on the next edge. From then until reset, the PC stays fixed, no register changes and `dmem_we` stays low.
- R10: Each instruction other than a branch or a jump advances the PC by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the instruction being fetched (the registered PC) |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 16 | Data-memory word address for a load or a store |
| dmem_wdata | output | 16 | Word to be stored |
| dmem_we | output | 1 | Store strobe, sampled at the rising edge |
| dmem_rdata | input | 16 | Word at `dmem_addr`, same cycle |
| halt | output | 1 | Registered, sticky stop indication |

## Verification
The hardest case to reach from the ports is a register-jump whose link and target registers are the same. Done wrong, it jumps to the freshly written link value and the error shows only as a wrong fetch address one cycle later. The program loads a known target into a register, executes a jump that both reads and overwrites that register, and then stores the register so the link value appears on `dmem_wdata`. A countdown loop closed by a negative-offset branch, a store to address -1 that wraps, and a write to register 0 followed by a store of it cover the other corners. The behavioural model compares every output on every cycle.

// File: rtl/core16_pkg.sv
package core16_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 3;
  localparam int IMM_S_W = 7;
  localparam int IMM_U_W = 10;
  localparam int LOW_PAD = WORD_W - IMM_U_W;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_ADDI  = 3'b001,
    OP_NAND  = 3'b010,
    OP_UPPER = 3'b011,
    OP_STORE = 3'b100,
    OP_LOAD  = 3'b101,
    OP_BREQ  = 3'b110,
    OP_JLINK = 3'b111
  } opcode_t;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_UPPER,
    WB_LOAD,
    WB_LINK
  } wb_src_t;

  typedef struct packed {
    logic [FIELD_W-1:0] ra;
    logic [FIELD_W-1:0] rb;
    logic [FIELD_W-1:0] rc;
    logic [WORD_W-1:0]  imm_s;
    logic [IMM_U_W-1:0] imm_u;
    logic               use_imm;
    logic               alu_nand;
    logic               src2_is_a;
    logic               reg_we;
    wb_src_t            wb;
    logic               mem_we;
    logic               is_branch;
    logic               is_jump;
    logic               is_halt;
  } ctrl_t;
endpackage

// File: rtl/core16_decode.sv
module core16_decode
  import core16_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output ctrl_t             ctrl
);
  opcode_t op;

  always_comb begin
    op             = opcode_t'(instr[15:13]);
    ctrl           = '0;
    ctrl.ra        = instr[12:10];
    ctrl.rb        = instr[9:7];
    ctrl.rc        = instr[2:0];
    ctrl.imm_s     = {{(WORD_W-IMM_S_W){instr[IMM_S_W-1]}}, instr[IMM_S_W-1:0]};
    ctrl.imm_u     = instr[IMM_U_W-1:0];
    ctrl.wb        = WB_ALU;
    case (op)
      OP_ADD:   ctrl.reg_we = 1'b1;
      OP_ADDI:  begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_NAND:  begin
        ctrl.reg_we   = 1'b1;
        ctrl.alu_nand = 1'b1;
      end
      OP_UPPER: begin
        ctrl.reg_we = 1'b1;
        ctrl.wb     = WB_UPPER;
      end
      OP_STORE: begin
        ctrl.mem_we    = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.src2_is_a = 1'b1;
      end
      OP_LOAD:  begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.wb      = WB_LOAD;
      end
      OP_BREQ:  begin
        ctrl.is_branch = 1'b1;
        ctrl.src2_is_a = 1'b1;
      end
      default:  begin
        ctrl.is_jump = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.wb      = WB_LINK;
        ctrl.is_halt = (instr[12:10] == '0) && (instr[9:7] == '0) &&
                       (instr[IMM_S_W-1:0] == '0);
      end
    endcase
  end
endmodule

// File: rtl/core16_regfile.sv
module core16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  logic [DW-1:0] store [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) store[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : store[raddr[p]];
  end
endmodule

// File: rtl/core16_alu.sv
module core16_alu #(
  parameter int DW = 16
) (
  input  logic          nand_sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    if (nand_sel) y = ~(a & b);
    else          y = a + b;
  end
endmodule

// File: rtl/core16_nextpc.sv
module core16_nextpc #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] jump_target,
  input  logic          is_branch,
  input  logic          is_jump,
  input  logic          operands_eq,
  output logic [AW-1:0] pc_plus1,
  output logic [AW-1:0] pc_next
);
  logic [AW-1:0] br_target;

  always_comb begin
    pc_plus1  = pc + AW'(1);
    br_target = pc_plus1 + offset;
    if (is_jump)                       pc_next = jump_target;
    else if (is_branch && operands_eq) pc_next = br_target;
    else                               pc_next = pc_plus1;
  end
endmodule

// File: rtl/core16_top.sv
module core16_top
  import core16_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_data,
  output logic [WORD_W-1:0] dmem_addr,
  output logic [WORD_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [WORD_W-1:0] dmem_rdata,
  output logic              halt
);
  localparam int RAW = $clog2(NREG);

  logic [WORD_W-1:0] pc_q;
  logic              halt_q;
  ctrl_t             ctrl;
  logic [1:0][RAW-1:0]    rd_addr;
  logic [1:0][WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] val_b, val_2, alu_b, alu_y, wb_data;
  logic [WORD_W-1:0] pc_plus1, pc_next;
  logic              rf_we, halt_now;

  core16_decode u_dec (.instr(imem_data), .ctrl(ctrl));

  assign rd_addr[0] = ctrl.rb;
  assign rd_addr[1] = ctrl.src2_is_a ? ctrl.ra : ctrl.rc;
  assign val_b      = rd_data[0];
  assign val_2      = rd_data[1];

  core16_regfile #(.DW(WORD_W), .NREG(NREG), .NRD(2)) u_rf (
    .clk(clk), .we(rf_we), .waddr(ctrl.ra), .wdata(wb_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm_s : val_2;

  core16_alu #(.DW(WORD_W)) u_alu (
    .nand_sel(ctrl.alu_nand), .a(val_b), .b(alu_b), .y(alu_y)
  );

  core16_nextpc #(.AW(WORD_W)) u_npc (
    .pc(pc_q), .offset(ctrl.imm_s), .jump_target(val_b),
    .is_branch(ctrl.is_branch), .is_jump(ctrl.is_jump),
    .operands_eq(val_b == val_2), .pc_plus1(pc_plus1), .pc_next(pc_next)
  );

  always_comb begin
    case (ctrl.wb)
      WB_UPPER: wb_data = {ctrl.imm_u, {LOW_PAD{1'b0}}};
      WB_LOAD:  wb_data = dmem_rdata;
      WB_LINK:  wb_data = pc_plus1;
      default:  wb_data = alu_y;
    endcase
  end

  assign halt_now   = ctrl.is_halt && !halt_q;
  assign rf_we      = ctrl.reg_we && !halt_q && !ctrl.is_halt;
  assign dmem_we    = ctrl.mem_we && !halt_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = val_2;
  assign imem_addr  = pc_q;
  assign halt       = halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else if (!halt_q) begin
      if (halt_now) halt_q <= 1'b1;
      else          pc_q   <= pc_next;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (imem_addr == '0 && !halt));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(imem_addr));

  // R9
  halt_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> !dmem_we);

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> imem_data[15:13] == 3'b100);

  // R2
  zero_source_chk: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && imem_data[12:10] == 3'b000) |-> dmem_wdata == '0);

  // R10
  seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && imem_data[15] == 1'b0) |=> imem_addr == WORD_W'($past(imem_addr) + 1'b1));
endmodule

// File: tb/core16_top_tb.sv
`timescale 1ns/1ps
module core16_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halt;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  logic [15:0] mdmem [256];
  logic [15:0] mreg [8];
  logic [15:0] mpc;
  logic        mhalt;
  string       last_tag;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  core16_top u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .halt(halt)
  );

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  function automatic logic [15:0] rrr(input int op, input int a, input int b, input int c);
    return {op[2:0], a[2:0], b[2:0], 4'b0000, c[2:0]};
  endfunction
  function automatic logic [15:0] rri(input int op, input int a, input int b, input int imm);
    return {op[2:0], a[2:0], b[2:0], imm[6:0]};
  endfunction
  function automatic logic [15:0] ri(input int op, input int a, input int imm);
    return {op[2:0], a[2:0], imm[9:0]};
  endfunction

  function automatic logic [15:0] rv(input logic [2:0] x);
    return (x == 3'd0) ? 16'h0000 : mreg[x];
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] ins);
    case (ins[15:13])
      3'd0, 3'd2: return "R3";
      3'd1:       return "R4";
      3'd3:       return "R5";
      3'd4:       return (ins[12:10] == 3'd0) ? "R2" : "R6";
      3'd5:       return "R6";
      3'd6:       return "R7";
      default:    return (ins[12:0] == 13'd0) ? "R9" : "R8";
    endcase
  endfunction

  task automatic compare();
    logic [15:0] ins = imem[mpc[7:0]];
    string tg = tag_of(ins);
    logic [15:0] sx = {{9{ins[6]}}, ins[6:0]};
    chk(mhalt ? "R9" : last_tag, "imem_addr", imem_addr, mpc);
    chk("R9", "halt", {15'd0, halt}, {15'd0, mhalt});
    if (mhalt) chk("R9", "dmem_we", {15'd0, dmem_we}, 16'd0);
    else begin
      chk("R6", "dmem_we", {15'd0, dmem_we}, {15'd0, ins[15:13] == 3'd4});
      if (ins[15:13] == 3'd4 || ins[15:13] == 3'd5)
        chk("R6", "dmem_addr", dmem_addr, rv(ins[9:7]) + sx);
      if (ins[15:13] == 3'd4)
        chk(tg, "dmem_wdata", dmem_wdata, rv(ins[12:10]));
    end
  endtask

  task automatic step();
    logic [15:0] ins = imem[mpc[7:0]];
    logic [2:0]  a = ins[12:10];
    logic [2:0]  b = ins[9:7];
    logic [2:0]  c = ins[2:0];
    logic [15:0] sx = {{9{ins[6]}}, ins[6:0]};
    logic [15:0] nxt = mpc + 16'd1;
    logic [15:0] res = 16'h0;
    logic [15:0] ea = rv(b) + sx;
    logic        wr = 1'b1;
    if (mhalt) return;
    last_tag = tag_of(ins);
    case (ins[15:13])
      3'd0: res = rv(b) + rv(c);
      3'd1: res = ea;
      3'd2: res = ~(rv(b) & rv(c));
      3'd3: res = {ins[9:0], 6'd0};
      3'd4: begin mdmem[ea[7:0]] = rv(a); wr = 1'b0; end
      3'd5: res = mdmem[ea[7:0]];
      3'd6: begin
        wr = 1'b0;
        if (rv(a) == rv(b)) nxt = mpc + 16'd1 + sx;
      end
      default: begin
        if (a == 3'd0 && b == 3'd0 && ins[6:0] == 7'd0) begin
          mhalt = 1'b1; wr = 1'b0; nxt = mpc;
        end else begin
          res = mpc + 16'd1; nxt = rv(b);
        end
      end
    endcase
    if (wr && a != 3'd0) mreg[a] = res;
    if (!mhalt) mpc = nxt;
  endtask

  task automatic reset_phase();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "imem_addr after reset", imem_addr, 16'h0000);
    chk("R1", "halt after reset", {15'd0, halt}, 16'd0);
    chk("R1", "dmem_we after reset", {15'd0, dmem_we}, 16'd0);
    mpc = 16'h0; mhalt = 1'b0; last_tag = "R1";
    rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      compare();
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h0; dmem[i] = 16'h0; mdmem[i] = 16'h0;
    end
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0;
    imem[0]  = rri(1, 1, 0, 5);
    imem[1]  = rri(1, 2, 0, -3);
    imem[2]  = rrr(0, 3, 1, 2);
    imem[3]  = rrr(2, 4, 1, 2);
    imem[4]  = ri(3, 5, 10'h3FF);
    imem[5]  = rri(1, 5, 5, 63);
    imem[6]  = rri(1, 0, 1, 7);
    imem[7]  = rri(4, 0, 0, 10);
    imem[8]  = rri(4, 3, 0, 11);
    imem[9]  = rri(4, 4, 0, 12);
    imem[10] = rri(4, 5, 0, -1);
    imem[11] = rri(5, 6, 0, -1);
    imem[12] = rri(4, 6, 1, 6);
    imem[13] = rri(6, 1, 2, 5);
    imem[14] = rri(1, 7, 0, 1);
    imem[15] = rri(6, 7, 7, 2);
    imem[16] = rri(1, 7, 7, 1);
    imem[17] = rri(1, 7, 7, 1);
    imem[18] = rri(1, 6, 0, 22);
    imem[19] = rri(7, 6, 6, 0);
    imem[20] = rri(1, 7, 0, -64);
    imem[21] = rri(1, 7, 0, -64);
    imem[22] = rri(4, 6, 0, 13);
    imem[23] = rri(1, 2, 2, 1);
    imem[24] = rri(6, 2, 0, 1);
    imem[25] = rri(6, 0, 0, -3);
    imem[26] = rri(4, 2, 0, 14);
    imem[27] = rri(4, 7, 0, 15);
    imem[28] = rri(7, 0, 0, 0);
    reset_phase();
    run(50);
    reset_phase();
    run(50);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule